// File: doc/BRIEF.md
# Status Suspension Window Sequencer

This block opens a short window in which the processor runs with external interrupts masked and with word addressing forced, whatever the interrupt-enable and byte-mode flags hold. A dedicated instruction opens the window. Its low three bits give a length code. The window then lasts for the length code minus one completed instructions. The instruction that opens the window does not count toward it. When the block opens a window, it keeps a copy of the two flags. While the window is open, it drives both effective flags low.

When the last counted instruction completes, the window closes. For one cycle the block presents the kept flag values on a restore port, so that the flag registers outside the block can reload them. The effective outputs show the kept values during that same cycle. After that they follow the live flags again. If the opening instruction executes again while a window is open, the count starts over and the first kept copy is retained. This lets nested helper routines extend the window without losing the caller's state. Decoding of all other opcodes, and the flag registers themselves, are left to the surrounding pipeline.

Top module: `stat_suspend_seq`

## Requirements
- R1: An opening instruction is any word whose bits 15..3 equal 0x0D00, so 0x6800 to 0x6807, presented with `exec_stb` high. A window-length field (bits 2..0) of 2 or more starts a window. `exec_stb` with any other word changes nothing.
- R2: With a field value F of 2 to 7, `inhibit_on` rises in the cycle after the executing edge. It falls at the edge that samples the (F-1)th `instr_done` pulse after that executing edge.
- R3: A field value of 0 or 1 opens no window when none is open. `inhibit_on` stays low and the effective flags keep following the live flags.
- R4: While `inhibit_on` is high, `eff_ie` and `eff_byte` are both 0.
- R5: While `inhibit_on` and `restore_stb` are both low, `eff_ie` equals `live_ie` and `eff_byte` equals `live_byte`.
- R6: When the window closes, `restore_stb` is high for exactly one cycle, the same cycle in which `inhibit_on` first reads low. During that cycle `restore_ie` and `restore_byte` carry the live flags that were sampled when the window opened, and `eff_ie` and `eff_byte` show those same values.
- R7: An `instr_done` pulse in the same cycle as an opening-instruction execute, whatever its field value, is not counted.
- R8: An opening instruction with a field of 2 or more that executes while a window is open reloads the remaining count to F-1 and keeps the flags saved when the window first opened.
- R9: After synchronous reset, `inhibit_on`, `restore_stb`, `restore_ie` and `restore_byte` are 0.
- R10: An opening instruction with a field of 0 or 1 that executes while a window is open leaves the remaining count unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| instr_word | input | 16 | Instruction word being executed |
| exec_stb | input | 1 | Execute strobe for `instr_word` |
| instr_done | input | 1 | One-cycle pulse per completed instruction |
| live_ie | input | 1 | Current interrupt-enable flag |
| live_byte | input | 1 | Current byte-mode flag |
| eff_ie | output | 1 | Interrupt enable as seen by the rest of the core |
| eff_byte | output | 1 | Byte mode as seen by the rest of the core |
| inhibit_on | output | 1 | High while instructions remain in the window |
| restore_stb | output | 1 | One-cycle reload strobe for the flag registers |
| restore_ie | output | 1 | Kept interrupt-enable value to reload |
| restore_byte | output | 1 | Kept byte-mode value to reload |

## Verification
Windows are opened with field values 2, 4 and 7, each with a different saved flag pair. The live flags change during each window, which shows that the restore carries the copy taken at opening and not the present value. Field values 0 and 1 separate the zero-length cases from a real window. A near miss in bit 3 (0x6808) and a word outside the opcode group check that the decode does not match too widely. A completion pulse coinciding with the opening execute, a reload during a window, and a zero-length execute during a window each tell apart counting, reloading and saving behaviour that a plain down-counter would get wrong.

// File: rtl/stat_suspend_pkg.sv
package stat_suspend_pkg;

    localparam int unsigned WORD_W  = 16;
    localparam int unsigned LEN_W   = 3;
    localparam logic [WORD_W-1:0] GROUP_BASE = 16'h6800;

    typedef struct packed {
        logic ie;
        logic byte_md;
    } flag_pair_t;

    // Counted instructions for a length code: code minus one, never below zero.
    function automatic logic [LEN_W-1:0] span_of(input logic [LEN_W-1:0] code);
        return (code > LEN_W'(1)) ? code - LEN_W'(1) : '0;
    endfunction

endpackage

// File: rtl/ssq_decode.sv
module ssq_decode
    import stat_suspend_pkg::*;
#(
    parameter int unsigned W  = WORD_W,
    parameter int unsigned LW = LEN_W,
    parameter logic [W-1:0] BASE = GROUP_BASE
) (
    input  logic [W-1:0]  instr_word,
    input  logic          exec_stb,
    output logic          hit,
    output logic          arm,
    output logic [LW-1:0] span
);
    localparam int unsigned TAG_W = W - LW;

    logic [TAG_W-1:0] tag;
    logic [LW-1:0]    code;

    always_comb begin
        tag  = instr_word[W-1:LW];
        code = instr_word[LW-1:0];
        hit  = exec_stb && (tag == BASE[W-1:LW]);
        span = span_of(code);
        arm  = hit && (span != '0);
    end
endmodule

// File: rtl/ssq_window.sv
module ssq_window
    import stat_suspend_pkg::*;
#(
    parameter int unsigned LW = LEN_W
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          hit,
    input  logic          arm,
    input  logic [LW-1:0] span,
    input  logic          instr_done,
    output logic          inhibit_on,
    output logic          restore_stb
);
    logic [LW-1:0] left_q;
    logic          close_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            left_q  <= '0;
            close_q <= 1'b0;
        end else begin
            close_q <= 1'b0;
            if (arm) begin
                left_q <= span;
            end else if (instr_done && !hit && left_q != '0) begin
                left_q <= left_q - LW'(1);
                if (left_q == LW'(1)) close_q <= 1'b1;
            end
        end
    end

    assign inhibit_on  = (left_q != '0);
    assign restore_stb = close_q;

    assert_arm_opens_R2: assert property (@(posedge clk) disable iff (rst)
        arm |=> inhibit_on);
    assert_no_count_on_group_R7: assert property (@(posedge clk) disable iff (rst)
        (hit && !arm) |=> $stable(left_q));
    assert_close_follows_R6: assert property (@(posedge clk) disable iff (rst)
        restore_stb |-> (!inhibit_on && $past(inhibit_on)));
    assert_idle_stays_R3: assert property (@(posedge clk) disable iff (rst)
        (!arm && !inhibit_on) |=> (!inhibit_on && !restore_stb));
    assert_reset_clear_R9: assert property (@(posedge clk)
        rst |=> (!inhibit_on && !restore_stb));
endmodule

// File: rtl/ssq_keep.sv
module ssq_keep
    import stat_suspend_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic arm,
    input  logic inhibit_on,
    input  logic restore_stb,
    input  logic live_ie,
    input  logic live_byte,
    output logic eff_ie,
    output logic eff_byte,
    output logic restore_ie,
    output logic restore_byte
);
    flag_pair_t kept_q;
    flag_pair_t live;
    flag_pair_t shown;
    logic       capture;

    always_comb begin
        live.ie      = live_ie;
        live.byte_md = live_byte;
        capture      = arm && !inhibit_on;
        if (inhibit_on)       shown = '0;
        else if (restore_stb) shown = kept_q;
        else                  shown = live;
    end

    always_ff @(posedge clk) begin
        if (rst)          kept_q <= '0;
        else if (capture) kept_q <= live;
    end

    assign eff_ie       = shown.ie;
    assign eff_byte     = shown.byte_md;
    assign restore_ie   = kept_q.ie;
    assign restore_byte = kept_q.byte_md;

    assert_kept_on_reload_R8: assert property (@(posedge clk) disable iff (rst)
        (inhibit_on && arm) |=> $stable(kept_q));
    assert_kept_during_window_R6: assert property (@(posedge clk) disable iff (rst)
        (inhibit_on && !arm) |=> $stable(kept_q));
endmodule

// File: rtl/stat_suspend_seq.sv
module stat_suspend_seq
    import stat_suspend_pkg::*;
#(
    parameter int unsigned W  = WORD_W,
    parameter int unsigned LW = LEN_W,
    parameter logic [W-1:0] BASE = GROUP_BASE
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] instr_word,
    input  logic         exec_stb,
    input  logic         instr_done,
    input  logic         live_ie,
    input  logic         live_byte,
    output logic         eff_ie,
    output logic         eff_byte,
    output logic         inhibit_on,
    output logic         restore_stb,
    output logic         restore_ie,
    output logic         restore_byte
);
    logic          hit;
    logic          arm;
    logic [LW-1:0] span;

    ssq_decode #(.W(W), .LW(LW), .BASE(BASE)) u_decode (
        .instr_word (instr_word),
        .exec_stb   (exec_stb),
        .hit        (hit),
        .arm        (arm),
        .span       (span)
    );

    ssq_window #(.LW(LW)) u_window (
        .clk         (clk),
        .rst         (rst),
        .hit         (hit),
        .arm         (arm),
        .span        (span),
        .instr_done  (instr_done),
        .inhibit_on  (inhibit_on),
        .restore_stb (restore_stb)
    );

    ssq_keep u_keep (
        .clk          (clk),
        .rst          (rst),
        .arm          (arm),
        .inhibit_on   (inhibit_on),
        .restore_stb  (restore_stb),
        .live_ie      (live_ie),
        .live_byte    (live_byte),
        .eff_ie       (eff_ie),
        .eff_byte     (eff_byte),
        .restore_ie   (restore_ie),
        .restore_byte (restore_byte)
    );

    assert_forced_low_R4: assert property (@(posedge clk) disable iff (rst)
        inhibit_on |-> (!eff_ie && !eff_byte));
    assert_pass_through_R5: assert property (@(posedge clk) disable iff (rst)
        (!inhibit_on && !restore_stb) |-> (eff_ie == live_ie && eff_byte == live_byte));
endmodule

// File: tb/test_stat_suspend_seq.sv
module test_stat_suspend_seq;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [15:0] instr_word = 16'h0000;
    logic        exec_stb = 1'b0;
    logic        instr_done = 1'b0;
    logic        live_ie = 1'b0;
    logic        live_byte = 1'b0;
    logic        eff_ie, eff_byte, inhibit_on, restore_stb, restore_ie, restore_byte;

    int checks = 0;
    int failures = 0;
    bit finished = 1'b0;

    always #10 clk = ~clk;

    stat_suspend_seq i_stat_suspend_seq (
        .clk(clk), .rst(rst), .instr_word(instr_word), .exec_stb(exec_stb),
        .instr_done(instr_done), .live_ie(live_ie), .live_byte(live_byte),
        .eff_ie(eff_ie), .eff_byte(eff_byte), .inhibit_on(inhibit_on),
        .restore_stb(restore_stb), .restore_ie(restore_ie), .restore_byte(restore_byte)
    );

    task automatic check(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            failures++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic step();
        @(posedge clk);
        #2;
    endtask

    task automatic exec(input logic [15:0] w, input logic done_too);
        instr_word = w; exec_stb = 1'b1; instr_done = done_too;
        step();
        exec_stb = 1'b0; instr_done = 1'b0; instr_word = 16'h0000;
    endtask

    task automatic done_pulse();
        instr_done = 1'b1;
        step();
        instr_done = 1'b0;
    endtask

    // status vector: {inhibit_on, restore_stb, eff_ie, eff_byte}
    function automatic int st();
        return {inhibit_on, restore_stb, eff_ie, eff_byte};
    endfunction

    task automatic t_reset();
        rst = 1'b1; step(); step(); rst = 1'b0;
        check("R9 inhibit_on", inhibit_on, 0);
        check("R9 restore_stb", restore_stb, 0);
        check("R9 restore pair", {restore_ie, restore_byte}, 0);
    endtask

    // window with field f, saved flags (ie, by); live flags flipped inside
    task automatic t_window(input int f, input logic ie, input logic by);
        live_ie = ie; live_byte = by;
        exec(16'h6800 | 16'(f), 1'b0);
        live_ie = ~ie; live_byte = ~by;
        #1;
        check("R2 opens", inhibit_on, 1);
        check("R4 forced low", {eff_ie, eff_byte}, 0);
        for (int i = 1; i < f - 1; i++) begin
            done_pulse();
            check("R2 still open", st(), 4'b1000);
        end
        done_pulse();
        check("R6 close cycle", st(), {2'b01, ie, by});
        check("R6 restore pair", {restore_ie, restore_byte}, {ie, by});
        step();
        check("R6 single strobe", restore_stb, 0);
        check("R5 pass through", {eff_ie, eff_byte}, {~ie, ~by});
    endtask

    task automatic t_zero_len();
        live_ie = 1'b1; live_byte = 1'b0;
        exec(16'h6800, 1'b0);
        check("R3 field 0", st(), 4'b0010);
        exec(16'h6801, 1'b0);
        check("R3 field 1", st(), 4'b0010);
        step();
        check("R3 field 1 later", st(), 4'b0010);
    endtask

    task automatic t_no_match();
        live_ie = 1'b1; live_byte = 1'b1;
        exec(16'h6808, 1'b0);
        check("R1 0x6808 ignored", st(), 4'b0011);
        exec(16'h4007, 1'b0);
        check("R1 0x4007 ignored", st(), 4'b0011);
        instr_word = 16'h6803; step(); instr_word = 16'h0000;
        check("R1 no strobe ignored", st(), 4'b0011);
    endtask

    task automatic t_coincident_done();
        live_ie = 1'b1; live_byte = 1'b0;
        exec(16'h6802, 1'b1);
        check("R7 own pulse not counted", inhibit_on, 1);
        done_pulse();
        check("R7 closes after one", st(), 4'b0110);
        step();
    endtask

    task automatic t_reload();
        live_ie = 1'b1; live_byte = 1'b1;
        exec(16'h6803, 1'b0);
        done_pulse();
        live_ie = 1'b0; live_byte = 1'b0;
        exec(16'h6803, 1'b0);
        done_pulse();
        check("R8 reloaded count", inhibit_on, 1);
        done_pulse();
        check("R8 original flags kept", st(), 4'b0111);
        step();
    endtask

    task automatic t_zero_in_window();
        live_ie = 1'b0; live_byte = 1'b1;
        exec(16'h6803, 1'b0);
        exec(16'h6801, 1'b1);
        check("R10 count kept", inhibit_on, 1);
        done_pulse();
        check("R10 still one left", inhibit_on, 1);
        done_pulse();
        check("R10 closes on count", st(), 4'b0101);
        step();
    endtask

    initial begin
        t_reset();
        t_window(2, 1'b1, 1'b0);
        t_window(4, 1'b0, 1'b1);
        t_window(7, 1'b1, 1'b1);
        t_zero_len();
        t_no_match();
        t_coincident_done();
        t_reload();
        t_zero_in_window();
        finished = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!finished) begin
            checks++; failures++;
            $display("FAIL watchdog actual=0 expected=1");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end
endmodule